// File: doc/BRIEF.md
# PHY register access bridge

This block sits on the link side of a serial-bus controller. Through it, host software reads and writes the small register file of an attached PHY. The host sees one 32-bit command register on a simple register bus. A single write to that register starts a PHY transaction. The word carries these fields:

- a PHY register address,
- a write-data byte,
- a write-request flag,
- a read-request flag.

The block then drives a parameterised, fixed-length handshake toward the PHY. It reports the result in the same register, so software polls one location for both request and result.

A write request is acknowledged when its own flag drops back to zero. A read request sets a separate sticky done flag, and the byte returned by the PHY appears in an upper field of the word. Commands issued while a transaction is still running are discarded and flagged with a sticky error bit. Software clears that bit by writing it as one.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset the command register reads as all zeros, and phy_req and phy_commit are low.
- R2: An accepted command with a request bit set raises phy_req on the edge that accepts it. phy_req stays high for exactly XFER_CYCLES cycles, with phy_addr taken from bits 8 upward (ADDR_W bits), phy_wdata from bits 7:0, and phy_we equal to bit 14. A command with neither bit 14 nor bit 15 set starts no transaction.
- R3: Bit 14 (write request) reads 1 while a PHY write is in flight and reads 0 once it completes. On completion the PHY register at phy_addr holds the data byte.
- R4: Bit 15 (read request) reads 1 while a PHY read is in flight. On completion bit 15 clears, bit 31 (read done) sets, and bits 23:16 hold the byte the PHY returned.
- R5: Any accepted write to the command register clears bit 31, and bits 23:16 keep the last read byte.
- R6: When bits 14 and 15 are both set, only the PHY write is performed. Bit 15 reads 0, bit 31 stays 0, and bits 23:16 are unchanged.
- R7: A command register write that arrives while a transaction is running is dropped. It sets bit 30 (error), and it changes neither the in-flight PHY signals nor the stored fields.
- R8: Bit 30 is sticky. It is cleared only by reset or by an accepted write (one made while idle) with bit 30 set to 1.
- R9: Bus accesses to any offset other than CMD_OFFSET read as zero and have no effect on the register or on the PHY.
- R10: phy_commit is high for exactly one cycle per transaction. That cycle is the last cycle in which phy_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Register bus write strobe |
| bus_rd | input | 1 | Register bus read strobe |
| bus_addr | input | REG_AW | Register bus offset |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Registered read data, updated on the edge that takes a read |
| phy_req | output | 1 | PHY transaction in progress |
| phy_we | output | 1 | Transaction is a PHY write |
| phy_addr | output | ADDR_W | PHY register address |
| phy_wdata | output | 8 | PHY write data |
| phy_rdata | input | 8 | PHY read data, sampled during the phy_commit cycle |
| phy_commit | output | 1 | Final-cycle strobe: PHY stores write data or presents read data |

## Verification
Call E0 the edge that accepts a command. phy_req is high in the N cycles that follow E0 (N = XFER_CYCLES), and phy_commit is high only in the Nth of them. The register word shows completion from edge E_N onward. Because bus reads are registered, a read taken on edge E_N still returns the in-flight word and a read taken on E_(N+1) returns the completed one. The bench drives on falling edges, samples the PHY outputs one falling edge after each rising edge, and places its register reads on exactly those edges, so both the still-busy and the completed state are checked at their due cycles.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  // Command word layout; software and the PHY handshake depend on these.
  localparam int WDATA_LSB = 0;
  localparam int ADDR_LSB  = 8;
  localparam int WREQ_BIT  = 14;
  localparam int RREQ_BIT  = 15;
  localparam int RDATA_LSB = 16;
  localparam int ERR_BIT   = 30;
  localparam int DONE_BIT  = 31;
  localparam int MAX_ADDR_W = WREQ_BIT - ADDR_LSB;

  typedef enum logic {XF_IDLE, XF_RUN} xfer_state_e;
endpackage

// File: rtl/pb_bus_slave.sv
module pb_bus_slave #(
  parameter int REG_AW     = 4,
  parameter int CMD_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       reg_word,
  output logic              wr_hit,
  output logic [31:0]       rdata
);
  localparam logic [REG_AW-1:0] OFS = REG_AW'(CMD_OFFSET);

  logic hit;
  assign hit    = sel && (addr == OFS);
  assign wr_hit = hit && wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (sel && rd) begin
      rdata <= hit ? reg_word : '0;
    end
  end
endmodule

// File: rtl/pb_xfer_fsm.sv
module pb_xfer_fsm
  import phy_bridge_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int XFER_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        start_wdata,
  output logic              phy_req,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [7:0]        phy_wdata,
  output logic              phy_commit
);
  localparam int CNT_W = (XFER_CYCLES > 1) ? $clog2(XFER_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(XFER_CYCLES - 1);

  xfer_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= XF_IDLE;
      cnt_q     <= '0;
      phy_we    <= 1'b0;
      phy_addr  <= '0;
      phy_wdata <= '0;
    end else begin
      case (state_q)
        XF_IDLE: begin
          if (start) begin
            state_q   <= XF_RUN;
            cnt_q     <= '0;
            phy_we    <= start_we;
            phy_addr  <= start_addr;
            phy_wdata <= start_wdata;
          end
        end
        default: begin
          if (cnt_q == LAST) begin
            state_q <= XF_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign phy_req    = (state_q == XF_RUN);
  assign phy_commit = (state_q == XF_RUN) && (cnt_q == LAST);
endmodule

// File: rtl/pb_cmd_reg.sv
module pb_cmd_reg
  import phy_bridge_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              commit,
  input  logic [7:0]        phy_rdata,
  output logic [31:0]       reg_word,
  output logic              start,
  output logic              start_we,
  output logic [ADDR_W-1:0] start_addr,
  output logic [7:0]        start_wdata
);
  logic [7:0]        wd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wreq_q, rreq_q, err_q, done_q;
  logic [7:0]        rd_q;
  logic              accept, req_w, req_r;

  assign req_w       = wdata[WREQ_BIT];
  assign req_r       = wdata[RREQ_BIT];
  assign accept      = wr_hit && !busy;
  assign start       = accept && (req_w || req_r);
  assign start_we    = req_w;
  assign start_addr  = wdata[ADDR_LSB +: ADDR_W];
  assign start_wdata = wdata[WDATA_LSB +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q   <= '0;
      addr_q <= '0;
      wreq_q <= 1'b0;
      rreq_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else if (accept) begin
      wd_q   <= start_wdata;
      addr_q <= start_addr;
      wreq_q <= req_w;
      rreq_q <= req_r && !req_w;
      done_q <= 1'b0;
      if (wdata[ERR_BIT]) err_q <= 1'b0;
    end else begin
      if (wr_hit) err_q <= 1'b1;
      if (commit) begin
        wreq_q <= 1'b0;
        if (rreq_q) begin
          rreq_q <= 1'b0;
          done_q <= 1'b1;
          rd_q   <= phy_rdata;
        end
      end
    end
  end

  always_comb begin
    reg_word                       = '0;
    reg_word[WDATA_LSB +: 8]       = wd_q;
    reg_word[ADDR_LSB +: ADDR_W]   = addr_q;
    reg_word[WREQ_BIT]             = wreq_q;
    reg_word[RREQ_BIT]             = rreq_q;
    reg_word[RDATA_LSB +: 8]       = rd_q;
    reg_word[ERR_BIT]              = err_q;
    reg_word[DONE_BIT]             = done_q;
  end

  // Reserved write bits carry no meaning.
  logic unused_hi;
  assign unused_hi = ^{wdata[DONE_BIT], wdata[ERR_BIT-1:RDATA_LSB]};
  generate
    if (ADDR_W < MAX_ADDR_W) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^wdata[WREQ_BIT-1:ADDR_LSB+ADDR_W];
    end
  endgenerate
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge #(
  parameter int ADDR_W      = 4,
  parameter int REG_AW      = 4,
  parameter int CMD_OFFSET  = 0,
  parameter int XFER_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              phy_req,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [7:0]        phy_wdata,
  input  logic [7:0]        phy_rdata,
  output logic              phy_commit
);
  logic              wr_hit;
  logic [31:0]       reg_word;
  logic              start, start_we;
  logic [ADDR_W-1:0] start_addr;
  logic [7:0]        start_wdata;

  pb_bus_slave #(.REG_AW(REG_AW), .CMD_OFFSET(CMD_OFFSET)) u_bus (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
    .addr(bus_addr), .reg_word(reg_word), .wr_hit(wr_hit), .rdata(bus_rdata)
  );

  pb_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wdata(bus_wdata),
    .busy(phy_req), .commit(phy_commit), .phy_rdata(phy_rdata),
    .reg_word(reg_word), .start(start), .start_we(start_we),
    .start_addr(start_addr), .start_wdata(start_wdata)
  );

  pb_xfer_fsm #(.ADDR_W(ADDR_W), .XFER_CYCLES(XFER_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .start_we(start_we),
    .start_addr(start_addr), .start_wdata(start_wdata),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_commit(phy_commit)
  );
endmodule

// File: rtl/phy_reg_bridge_chk.sv
module phy_reg_bridge_chk #(
  parameter int ADDR_W      = 4,
  parameter int REG_AW      = 4,
  parameter int CMD_OFFSET  = 0,
  parameter int XFER_CYCLES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic              req_w,
  input logic              req_r,
  input logic              phy_req,
  input logic              phy_we,
  input logic [ADDR_W-1:0] phy_addr,
  input logic [7:0]        phy_wdata,
  input logic              phy_commit
);
  logic [15:0] run_cnt;
  logic        cmd_hit;
  assign cmd_hit = bus_sel && bus_wr && (bus_addr == REG_AW'(CMD_OFFSET));

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (phy_req) run_cnt <= run_cnt + 1'b1;
    else run_cnt <= '0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!phy_req && !phy_commit));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && !phy_req && (req_w || req_r)) |=> (phy_req && (phy_we == $past(req_w))));

  // R2
  req_len_chk: assert property (@(posedge clk) disable iff (rst)
    phy_req |-> (run_cnt < 16'(XFER_CYCLES)));

  // R10
  commit_last_chk: assert property (@(posedge clk) disable iff (rst)
    phy_commit |-> (phy_req && (run_cnt == 16'(XFER_CYCLES - 1))));

  // R10
  commit_single_chk: assert property (@(posedge clk) disable iff (rst)
    phy_commit |=> (!phy_commit && !phy_req));

  // R7
  inflight_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (phy_req && $past(phy_req)) |-> ($stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)));
endmodule

bind phy_reg_bridge phy_reg_bridge_chk #(
  .ADDR_W(ADDR_W), .REG_AW(REG_AW), .CMD_OFFSET(CMD_OFFSET), .XFER_CYCLES(XFER_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .req_w(bus_wdata[14]), .req_r(bus_wdata[15]), .phy_req(phy_req), .phy_we(phy_we),
  .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_commit(phy_commit)
);

// File: tb/sim_phy_reg_bridge.sv
module sim_phy_reg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 4;
  localparam int RAW = 4;
  localparam int OFS = 0;
  localparam int N   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [RAW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic phy_req, phy_we, phy_commit;
  logic [AW-1:0] phy_addr;
  logic [7:0] phy_wdata, phy_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_reg_bridge #(.ADDR_W(AW), .REG_AW(RAW), .CMD_OFFSET(OFS), .XFER_CYCLES(N)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_rdata(phy_rdata), .phy_commit(phy_commit)
  );

  // PHY model: small register file, written on the commit cycle.
  logic [7:0] phy_regs [16];
  logic [7:0] exp_regs [16];
  initial for (int i = 0; i < 16; i++) begin
    phy_regs[i] = 8'(i * 17) ^ 8'h5A;
    exp_regs[i] = 8'(i * 17) ^ 8'h5A;
  end
  assign phy_rdata = phy_regs[phy_addr];
  always @(posedge clk) if (phy_commit && phy_we) phy_regs[phy_addr] <= phy_wdata;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] last_rd = 8'h00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [7:0] wd, input logic [3:0] a,
      input bit wq, input bit rq, input logic [7:0] rd, input bit er, input bit dn);
    return {dn, er, 6'd0, rd, rq, wq, 2'b00, a, wd};
  endfunction

  function automatic logic [31:0] cmd(input bit rq, input bit wq, input bit er,
      input logic [3:0] a, input logic [7:0] d);
    return {1'b0, er, 14'd0, rq, wq, 2'b00, a, d};
  endfunction

  // Tasks start and end on a falling edge.
  task automatic bus_write(input logic [RAW-1:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [RAW-1:0] a, output logic [31:0] d);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
    d = bus_rdata;
  endtask

  // {op[1]=read, op[0]=write, addr, data}
  localparam logic [13:0] VEC [8] = '{
    {2'd2, 4'd3,  8'h00}, {2'd1, 4'd3,  8'hA5}, {2'd2, 4'd3,  8'h00},
    {2'd3, 4'd5,  8'h3C}, {2'd2, 4'd5,  8'h00}, {2'd1, 4'd15, 8'hFF},
    {2'd2, 4'd15, 8'h00}, {2'd2, 4'd0,  8'h00}
  };

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 phy_req", 32'(phy_req), 0);
    chk("R1 phy_commit", 32'(phy_commit), 0);
    bus_read(RAW'(OFS), r);
    chk("R1 reg after reset", r, 0);

    for (int v = 0; v < 8; v++) begin
      logic [1:0] op; logic [3:0] a; logic [7:0] d; string tag;
      {op, a, d} = VEC[v];
      tag = (op == 2'd3) ? "R6" : (op[0] ? "R3" : "R4");
      bus_write(RAW'(OFS), cmd(op[1], op[0], 0, a, d));
      chk("R2 phy_we", 32'(phy_we), 32'(op[0]));
      chk("R2 phy_addr", 32'(phy_addr), 32'(a));
      if (op[0]) chk("R2 phy_wdata", 32'(phy_wdata), 32'(d));
      for (int k = 0; k < N; k++) begin
        chk("R2 phy_req high", 32'(phy_req), 1);
        chk("R10 commit position", 32'(phy_commit), 32'(k == N-1));
        @(negedge clk);
      end
      chk("R2 phy_req low after N", 32'(phy_req), 0);
      if (op[0]) exp_regs[a] = d; else last_rd = exp_regs[a];
      bus_read(RAW'(OFS), r);
      chk(tag, r, word(d, a, 0, 0, last_rd, 0, op == 2'd2));
      if (op[0]) chk("R3 phy file", 32'(phy_regs[a]), 32'(exp_regs[a]));
    end

    // R3 in flight, R7 drop while busy
    bus_write(RAW'(OFS), cmd(0, 1, 0, 4'd2, 8'h11));
    bus_read(RAW'(OFS), r);
    chk("R3 wreq set in flight", r, word(8'h11, 4'd2, 1, 0, last_rd, 0, 0));
    bus_write(RAW'(OFS), cmd(1, 0, 0, 4'd7, 8'h99));
    chk("R7 phy_addr kept", 32'(phy_addr), 2);
    chk("R7 phy_we kept", 32'(phy_we), 1);
    repeat (N) @(negedge clk);
    exp_regs[2] = 8'h11;
    bus_read(RAW'(OFS), r);
    chk("R7 dropped, error set", r, word(8'h11, 4'd2, 0, 0, last_rd, 1, 0));
    chk("R7 write landed", 32'(phy_regs[2]), 32'h11);

    // R8 sticky error, then write-one-to-clear
    bus_write(RAW'(OFS), cmd(0, 0, 0, 4'd1, 8'h22));
    chk("R2 no request no xfer", 32'(phy_req), 0);
    bus_read(RAW'(OFS), r);
    chk("R8 error sticky", r, word(8'h22, 4'd1, 0, 0, last_rd, 1, 0));
    bus_write(RAW'(OFS), cmd(0, 0, 1, 4'd1, 8'h22));
    bus_read(RAW'(OFS), r);
    chk("R8 error cleared", r, word(8'h22, 4'd1, 0, 0, last_rd, 0, 0));

    // R4 then R5: read, then new command clears done
    bus_write(RAW'(OFS), cmd(1, 0, 0, 4'd2, 8'h00));
    repeat (N) @(negedge clk);
    last_rd = exp_regs[2];
    bus_read(RAW'(OFS), r);
    chk("R4 read done", r, word(8'h00, 4'd2, 0, 0, 8'h11, 0, 1));
    bus_write(RAW'(OFS), cmd(0, 0, 0, 4'd4, 8'h00));
    bus_read(RAW'(OFS), r);
    chk("R5 done cleared", r, word(8'h00, 4'd4, 0, 0, 8'h11, 0, 0));

    // R9 other offsets
    bus_write(RAW'(OFS + 1), 32'hFFFF_FFFF);
    chk("R9 no xfer", 32'(phy_req), 0);
    bus_read(RAW'(OFS), r);
    chk("R9 reg unchanged", r, word(8'h00, 4'd4, 0, 0, 8'h11, 0, 0));
    bus_read(RAW'(OFS + 1), r);
    chk("R9 other reads zero", r, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule